// File: doc/BRIEF.md
# Capture Input Glitch Filter

This block cleans up a single raw timer capture input before any edge logic sees it. The raw pin is first brought into the clock domain through a short synchronizer chain. A local rate generator then produces a sampling strobe at the peripheral clock divided by 1, 2, 4, 8, 16 or 32. A run-length filter moves its output to a new level only once a required number N of consecutive samples have all shown that level.

One 4-bit filter code selects both the divider and N from a fixed table. Code zero turns filtering off, and the output then tracks the synchronized input on every clock. Changing the code restarts the sampling divider and the run count. The filtered level held at that moment stays as it is. The sample strobe is brought out so that other logic can line up with the sampling instants.

Top module: `capture_glitch_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `filt_out` is 0 and both the divider and the run counter are cleared.
- R2: The raw input passes through a two-flop synchronizer. With `filt_code` = 0 there is no filtering, and `filt_out` takes a new raw level on the third rising clock edge after the change.
- R3: The code sets the sampling divider D. Codes 0 to 3 give D=1. Codes 4 and 5 give 2, codes 6 and 7 give 4, and codes 8 and 9 give 8. Codes 10, 11 and 12 give 16, and codes 13, 14 and 15 give 32. `sample_tick` pulses for one cycle once every D cycles, so any window of 64·D cycles holds exactly 64 pulses.
- R4: The code sets the run length N. Codes 1, 2 and 3 give 2, 4 and 8. Among codes 4 to 9, even codes give 6 and odd codes give 8. Codes 10 and 13 give 5, codes 11 and 14 give 6, and codes 12 and 15 give 8. Suppose the code changes on the same cycle as a raw step, after a long steady state. Then `filt_out` takes the new level on edge N·D+1 when D>1, and on edge N+2 when D=1.
- R5: A raw pulse lasting (N-1)·D cycles or less never reaches `filt_out`.
- R6: A sample that matches the current output level resets the run count. Two pulses of (N-1)·D cycles each, separated by D cycles at the old level, leave `filt_out` unchanged.
- R7: A code change clears the divider and the run counter and leaves `filt_out` as it was. Suppose the raw input is already steady at the new level when the code changes. Then the output switches on edge N·D+1 counted from the change (edge N+1 when D=1), with the new code's values.
- R8: With a nonzero code, `filt_out` changes only on a clock edge where `sample_tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_in | input | 1 | Unsynchronized capture input |
| filt_code | input | 4 | Joint divider / run-length selection code |
| filt_out | output | 1 | Filtered, synchronized level |
| sample_tick | output | 1 | One-cycle strobe at each sampling instant |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a 5-bit divider, a 3-bit run counter and the strobe output enabled. These widths are just enough for divider 32 and N=8, so every one of the 16 codes can be swept in a few thousand cycles. The sweep covers step latency in both polarities, pulse rejection, restart of the run count, strobe density and a code change in the middle of a run. It compares each result against latencies computed from D and N.

// File: rtl/cgf_pkg.sv
package cgf_pkg;

   localparam int unsigned CODE_W = 4;

   typedef struct packed {
      logic [2:0] div_log2;
      logic [3:0] run_len;
   } cgf_cfg_t;

   function automatic cgf_cfg_t cgf_decode(input logic [CODE_W-1:0] code);
      cgf_cfg_t c;
      case (code)
         4'd1:    c = '{div_log2: 3'd0, run_len: 4'd2};
         4'd2:    c = '{div_log2: 3'd0, run_len: 4'd4};
         4'd3:    c = '{div_log2: 3'd0, run_len: 4'd8};
         4'd4:    c = '{div_log2: 3'd1, run_len: 4'd6};
         4'd5:    c = '{div_log2: 3'd1, run_len: 4'd8};
         4'd6:    c = '{div_log2: 3'd2, run_len: 4'd6};
         4'd7:    c = '{div_log2: 3'd2, run_len: 4'd8};
         4'd8:    c = '{div_log2: 3'd3, run_len: 4'd6};
         4'd9:    c = '{div_log2: 3'd3, run_len: 4'd8};
         4'd10:   c = '{div_log2: 3'd4, run_len: 4'd5};
         4'd11:   c = '{div_log2: 3'd4, run_len: 4'd6};
         4'd12:   c = '{div_log2: 3'd4, run_len: 4'd8};
         4'd13:   c = '{div_log2: 3'd5, run_len: 4'd5};
         4'd14:   c = '{div_log2: 3'd5, run_len: 4'd6};
         4'd15:   c = '{div_log2: 3'd5, run_len: 4'd8};
         default: c = '{div_log2: 3'd0, run_len: 4'd1};
      endcase
      return c;
   endfunction

endpackage

// File: rtl/cgf_sync.sv
module cgf_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cgf_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/cgf_rate_gen.sv
module cgf_rate_gen #(
   parameter int unsigned DIV_W = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic [2:0] div_log2,
   output logic       tick
);
   if (DIV_W < 5) begin : g_bad_div_w
      $error("cgf_rate_gen: DIV_W must cover a divider of 32");
   end

   logic [DIV_W-1:0] div_cnt_q;
   logic [DIV_W-1:0] div_max;

   always_comb begin
      div_max = DIV_W'((32'd1 << div_log2) - 32'd1);
      tick    = !restart && (div_cnt_q == div_max);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                div_cnt_q <= '0;
      else if (restart || tick)  div_cnt_q <= '0;
      else                       div_cnt_q <= div_cnt_q + 1'b1;
   end

   // R3: the count never runs past the divider limit of a stable code
   assert_div_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |-> (div_cnt_q <= div_max));

   // R3: a divided rate never yields two strobes in a row
   assert_no_double_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div_max != '0) |=> !tick);

   // R7: a code change always restarts the divider
   assert_div_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (div_cnt_q == '0));

endmodule

// File: rtl/cgf_run_filter.sv
module cgf_run_filter #(
   parameter int unsigned RUN_W = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       bypass,
   input  logic       tick,
   input  logic       sample,
   input  logic [3:0] run_len,
   output logic       level
);
   if (RUN_W < 3) begin : g_bad_run_w
      $error("cgf_run_filter: RUN_W must count up to 7");
   end

   logic [RUN_W-1:0] run_cnt_q;
   logic [RUN_W-1:0] last_idx;
   logic             level_q;

   assign last_idx = RUN_W'(run_len - 4'd1);
   assign level    = level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q   <= 1'b0;
         run_cnt_q <= '0;
      end else if (bypass) begin
         level_q   <= sample;
         run_cnt_q <= '0;
      end else if (restart) begin
         run_cnt_q <= '0;
      end else if (tick) begin
         if (sample == level_q) begin
            run_cnt_q <= '0;
         end else if (run_cnt_q == last_idx) begin
            level_q   <= sample;
            run_cnt_q <= '0;
         end else begin
            run_cnt_q <= run_cnt_q + 1'b1;
         end
      end
   end

   // R2: without filtering the level follows the synchronized sample
   assert_bypass_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> (level_q == $past(sample)));

   // R4: the run count stays below N while the code is steady
   assert_run_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !bypass) |-> (run_cnt_q <= last_idx));

   // R6: a sample equal to the held level empties the run
   assert_run_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && !restart && tick && sample == level_q) |=> (run_cnt_q == '0));

   // R7: a code change clears the run and keeps the level
   assert_restart_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !bypass) |=> (run_cnt_q == '0 && $stable(level_q)));

endmodule

// File: rtl/capture_glitch_filter.sv
module capture_glitch_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DIV_W       = 5,
   parameter int unsigned RUN_W       = 3,
   parameter bit          HAS_STROBE  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       raw_in,
   input  logic [3:0] filt_code,
   output logic       filt_out,
   output logic       sample_tick
);
   import cgf_pkg::*;

   logic           sync_lvl;
   logic [3:0]     code_q;
   logic           restart;
   logic           bypass;
   logic           tick;
   cgf_cfg_t       cfg;

   always_ff @(posedge clk) begin
      if (!rst_n) code_q <= '0;
      else        code_q <= filt_code;
   end

   always_comb begin
      cfg     = cgf_decode(filt_code);
      restart = (filt_code != code_q);
      bypass  = (filt_code == '0);
   end

   cgf_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_in),
      .q_out (sync_lvl)
   );

   cgf_rate_gen #(.DIV_W(DIV_W)) rate_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .div_log2 (cfg.div_log2),
      .tick     (tick)
   );

   cgf_run_filter #(.RUN_W(RUN_W)) filt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .bypass  (bypass),
      .tick    (tick),
      .sample  (sync_lvl),
      .run_len (cfg.run_len),
      .level   (filt_out)
   );

   if (HAS_STROBE) begin : g_strobe
      assign sample_tick = tick;
   end else begin : g_no_strobe
      assign sample_tick = 1'b0;
   end

   // R8: with filtering on, the output moves only at a sampling instant
   assert_move_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_code != '0 && !tick) |=> $stable(filt_out));

   // R1: the first cycle out of reset shows a low output
   assert_reset_low_R1: assert property (@(posedge clk)
      !rst_n |=> !filt_out);

endmodule

// File: tb/capture_glitch_filter_tb_top.sv
module capture_glitch_filter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       raw_in = 1'b0;
   logic [3:0] filt_code = 4'd0;
   logic       filt_out;
   logic       sample_tick;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cycles <= cycles + 1;

   capture_glitch_filter dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .raw_in      (raw_in),
      .filt_code   (filt_code),
      .filt_out    (filt_out),
      .sample_tick (sample_tick)
   );

   function automatic int exp_div(input int c);
      if (c < 4)  return 1;
      if (c < 6)  return 2;
      if (c < 8)  return 4;
      if (c < 10) return 8;
      if (c < 13) return 16;
      return 32;
   endfunction

   function automatic int exp_len(input int c);
      if (c == 0) return 1;
      if (c < 4)  return 1 << c;
      if (c < 10) return (c % 2 == 0) ? 6 : 8;
      case ((c - 10) % 3)
         0:       return 5;
         1:       return 6;
         default: return 8;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // bring the output to level lv through the unfiltered path, then hold code c
   task automatic settle(input bit lv, input int c);
      @(negedge clk);
      filt_code = 4'd0;
      raw_in    = lv;
      cyc(6);
      filt_code = 4'(c);
      cyc(4);
   endtask

   // count edges until filt_out reaches lv, up to lim
   task automatic edges_to(input bit lv, input int lim, output int got);
      got = -1;
      for (int k = 1; k <= lim; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (filt_out == lv && got < 0) got = k;
      end
   endtask

   initial begin
      int got, t, d, n, cnt;
      bit lv;
      cyc(3);
      check(filt_out == 1'b0, "R1 reset low", filt_out, 0);
      check(sample_tick == 1'b1, "R1 divider cleared", sample_tick, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(filt_out == 1'b0, "R1 low after release", filt_out, 0);

      // R2: unfiltered latency in both polarities
      for (int p = 0; p < 2; p++) begin
         lv = bit'(p);
         settle(lv, 1);
         filt_code = 4'd0;
         raw_in    = !lv;
         edges_to(!lv, 10, got);
         check(got == 3, "R2 bypass latency", got, 3);
      end

      // R4: step latency for every filtering code, both polarities
      for (int c = 1; c < 16; c++) begin
         for (int p = 0; p < 2; p++) begin
            lv = bit'(p);
            d = exp_div(c);
            n = exp_len(c);
            t = (d == 1) ? n + 2 : n * d + 1;
            settle(lv, 0);
            filt_code = 4'(c);
            raw_in    = !lv;
            edges_to(!lv, t + 4, got);
            check(got == t, $sformatf("R4 step latency code %0d", c), got, t);
         end
      end

      // R3: strobe density per code
      for (int c = 0; c < 16; c++) begin
         d = exp_div(c);
         @(negedge clk);
         filt_code = 4'(c);
         cyc(3);
         cnt = 0;
         for (int k = 0; k < 64 * d; k++) begin
            if (sample_tick) cnt++;
            @(negedge clk);
         end
         check(cnt == 64, $sformatf("R3 strobe count code %0d", c), cnt, 64);
      end

      // R5 and R6: short pulses, alone and in pairs, are dropped
      for (int c = 1; c < 16; c++) begin
         d = exp_div(c);
         n = exp_len(c);
         settle(1'b0, c);
         raw_in = 1'b1;
         cyc((n - 1) * d);
         raw_in = 1'b0;
         got = 0;
         for (int k = 0; k < n * d + 6; k++) begin
            if (filt_out) got = 1;
            @(negedge clk);
         end
         check(got == 0, $sformatf("R5 pulse rejected code %0d", c), got, 0);
         raw_in = 1'b1;
         cyc((n - 1) * d);
         raw_in = 1'b0;
         cyc(d);
         raw_in = 1'b1;
         cyc((n - 1) * d);
         raw_in = 1'b0;
         for (int k = 0; k < n * d + 6; k++) begin
            if (filt_out) got = 1;
            @(negedge clk);
         end
         check(got == 0, $sformatf("R6 run restart code %0d", c), got, 0);
      end

      // R7: code change part-way through a run
      for (int p = 0; p < 2; p++) begin
         lv = bit'(p);
         settle(lv, 0);
         filt_code = 4'd3;
         raw_in    = !lv;
         cyc(4);
         check(filt_out == lv, "R7 level before change", filt_out, lv);
         filt_code = 4'd4;
         t = exp_len(4) * exp_div(4) + 1;
         edges_to(!lv, t + 4, got);
         check(got == t, "R7 restart latency", got, t);
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      wait (cycles >= WATCHDOG);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule